// File: doc/BRIEF.md
# Twelve-Channel ADC Scan Controller Register Core

This block is the register-side front end of a successive-approximation converter with twelve analog inputs. Software programs it over a simple 32-bit register port. It can enable or disable channels and interrupt sources one bit at a time, pick how conversions are started, and mark even/odd channel pairs as differential inputs. It then reads back one result register per channel, a most-recent-result register and the flag words. The analog converter sits outside the block. The core asks for one conversion at a time on a request/acknowledge port and receives a 12-bit code with each acknowledge.

A scan starts on a software start command or on a selected edge of an external trigger pin. The scan visits every eligible channel once, in ascending index order. Each result sets a ready flag for its channel and a global data-ready flag. An interrupt line is raised whenever a flag is set and its mask bit is enabled. Reads clear the flags, and a second result that lands on an unread channel is recorded as an overrun.

Top module: `adcRegCore`

## Requirements
- R1: A write of 1 to bit 0 at offset 0x00 returns every register to zero, aborts any scan and drops irq on the next cycle. The same state follows rstN. Offset 0xFC always reads the VERSION_ID parameter.
- R2: Writing at 0x10 sets the channel-enable bits that are 1 in bits [11:0], and writing at 0x14 clears them; 0x18 reads the enable word. Offsets 0x24/0x28 set and clear the interrupt mask (bits [11:0] per channel, bit 24 data-ready), which reads at 0x2C. Zero bits have no effect.
- R3: A write of 1 to bit 1 at 0x00 starts a scan. convReq is held with a steady convChan until convAck. Eligible channels are requested in ascending order, one at a time, and convReq drops after the last one. With no eligible channel, no request is made.
- R4: On each acknowledge, convResult is stored in the channel's register at 0x50 + 4*channel, zero-extended. Status bit [channel] at 0x30 is set, and a read of that data register clears it.
- R5: The last-result register at 0x20 holds the code in [11:0], the channel in [27:24] and the differential flag in bit 28. Each store sets status bit 24, and a read of 0x20 clears it.
- R6: irq is high exactly when the status word at 0x30 ANDed with the mask at 0x2C is nonzero.
- R7: The trigger mode in bits [2:0] at 0xC0 selects the start source. 0 is software only, 1 the rising edge of extTrig, 2 the falling edge and 3 either edge. extTrig passes through two synchronising flops first.
- R8: A start command or trigger edge that arrives while a scan is running is ignored.
- R9: If a result is stored to a channel whose status bit is still set, overrun bit [channel] at 0x3C is set. A read of 0x3C clears the overrun word.
- R10: Pair k is differential when bits 16+2k and 17+2k at 0x4C are both set. The even channel is then requested with convDiff high, and its data register reads the result sign-extended to 32 bits. The odd channel is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects at the clock edge) |
| regAddr | input | 8 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, valid in the same cycle |
| extTrig | input | 1 | Asynchronous external trigger |
| convReq | output | 1 | Conversion request to the converter |
| convChan | output | 4 | Channel index being requested |
| convDiff | output | 1 | Requested channel is the even half of a differential pair |
| convAck | input | 1 | Converter result is valid |
| convResult | input | 12 | Conversion code |
| irq | output | 1 | Interrupt request |

## Verification
Random enable, mask and pair-selection words are applied, each followed by a software start. This shows whether the scan order follows the enable bits, whether differential pairs fold the odd channel away, and whether the status, overrun and interrupt words track which results were read or left unread. Enable words with no eligible channel separate a real scan from a spurious request. Directed edge sequences are run in each trigger mode, so that each edge polarity is shown to start or not start a scan. Start commands and trigger edges injected in the middle of a scan, together with a soft reset while a request is pending, test the ignore and abort paths.

// File: rtl/adcRegPkg.sv
package adcRegPkg;
  localparam int NUM_CH   = 12;
  localparam int RES_W    = 12;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int NUM_PAIR = NUM_CH / 2;
  localparam int DIFF_LSB = 16;
  localparam int DRDY_BIT = 24;
  localparam int LCH_LSB  = 24;
  localparam int LDIF_BIT = 28;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_CHSET = 8'h10;
  localparam logic [7:0] A_CHCLR = 8'h14;
  localparam logic [7:0] A_CHEN  = 8'h18;
  localparam logic [7:0] A_LAST  = 8'h20;
  localparam logic [7:0] A_IMSET = 8'h24;
  localparam logic [7:0] A_IMCLR = 8'h28;
  localparam logic [7:0] A_IMASK = 8'h2C;
  localparam logic [7:0] A_STAT  = 8'h30;
  localparam logic [7:0] A_OVR   = 8'h3C;
  localparam logic [7:0] A_DIFF  = 8'h4C;
  localparam logic [7:0] A_DATA  = 8'h50;
  localparam logic [7:0] A_TRIG  = 8'hC0;
  localparam logic [7:0] A_VER   = 8'hFC;

  typedef enum logic [2:0] {
    TRG_SOFT = 3'd0,
    TRG_RISE = 3'd1,
    TRG_FALL = 3'd2,
    TRG_BOTH = 3'd3
  } trigMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            clrAll;
    logic            store;
    logic [CH_W-1:0] storeCh;
    logic            storeDiff;
    logic            rdLast;
    logic            rdCh;
    logic [CH_W-1:0] rdChIdx;
    logic            rdOvr;
  } dpStrobe_t;
endpackage

// File: rtl/adcData.sv
module adcData
  import adcRegPkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strb,
  input  logic [RES_W-1:0]               convResult,
  output logic [NUM_CH-1:0][RES_W-1:0]   chRes,
  output logic [NUM_CH-1:0]              chDiff,
  output logic [NUM_CH-1:0]              chRdy,
  output logic [NUM_CH-1:0]              chOvr,
  output logic                           drdy,
  output logic [RES_W-1:0]               lastRes,
  output logic [CH_W-1:0]                lastCh,
  output logic                           lastDiff
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [RES_W-1:0] resQ;
    logic             diffQ, rdyQ, ovrQ;
    logic             hit, rdHit;
    assign hit   = strb.store && (strb.storeCh == CH_W'(c));
    assign rdHit = strb.rdCh && (strb.rdChIdx == CH_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resQ <= '0; diffQ <= 1'b0; rdyQ <= 1'b0; ovrQ <= 1'b0;
      end else if (strb.clrAll) begin
        resQ <= '0; diffQ <= 1'b0; rdyQ <= 1'b0; ovrQ <= 1'b0;
      end else if (hit) begin
        resQ  <= convResult;
        diffQ <= strb.storeDiff;
        rdyQ  <= 1'b1;
        if (rdyQ) ovrQ <= 1'b1;
        else if (strb.rdOvr) ovrQ <= 1'b0;
      end else begin
        if (rdHit) rdyQ <= 1'b0;
        if (strb.rdOvr) ovrQ <= 1'b0;
      end
    end

    assign chRes[c]  = resQ;
    assign chDiff[c] = diffQ;
    assign chRdy[c]  = rdyQ;
    assign chOvr[c]  = ovrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drdy <= 1'b0; lastRes <= '0; lastCh <= '0; lastDiff <= 1'b0;
    end else if (strb.clrAll) begin
      drdy <= 1'b0; lastRes <= '0; lastCh <= '0; lastDiff <= 1'b0;
    end else if (strb.store) begin
      drdy     <= 1'b1;
      lastRes  <= convResult;
      lastCh   <= strb.storeCh;
      lastDiff <= strb.storeDiff;
    end else if (strb.rdLast) begin
      drdy <= 1'b0;
    end
  end
endmodule

// File: rtl/adcCtrl.sv
module adcCtrl
  import adcRegPkg::*;
#(
  parameter logic [31:0] VERSION_ID = 32'h0001_0200
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrEn,
  input  logic                         regRdEn,
  input  logic [7:0]                   regAddr,
  input  logic [31:0]                  regWrData,
  output logic [31:0]                  regRdData,
  input  logic                         extTrig,
  output logic                         convReq,
  output logic [CH_W-1:0]              convChan,
  output logic                         convDiff,
  input  logic                         convAck,
  input  logic [NUM_CH-1:0][RES_W-1:0] chRes,
  input  logic [NUM_CH-1:0]            chDiff,
  input  logic [NUM_CH-1:0]            chRdy,
  input  logic [NUM_CH-1:0]            chOvr,
  input  logic                         drdy,
  input  logic [RES_W-1:0]             lastRes,
  input  logic [CH_W-1:0]              lastCh,
  input  logic                         lastDiff,
  output dpStrobe_t                    strb,
  output logic                         irqLine
);
  logic [NUM_CH-1:0]   chEn, irqEnCh, diffSel, elig;
  logic [NUM_PAIR-1:0] pairDiff;
  logic                irqEnDrdy;
  trigMode_e           trigMode;
  logic [1:0]          syncQ;
  logic                trigPrev, trigEdge;
  logic                busy;
  logic [CH_W-1:0]     curCh, firstCh, nextCh;
  logic                firstFound, nextFound;
  logic                swRst, swStart, startReq;
  logic                isData;
  logic [7:0]          dataOff;
  logic [CH_W-1:0]     rdIdx;

  // pair and eligibility decode
  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    assign pairDiff[k] = diffSel[2*k] & diffSel[2*k+1];
  end
  for (genvar c = 0; c < NUM_CH; c++) begin : g_elig
    if (c % 2 == 1) begin : g_odd
      assign elig[c] = chEn[c] & ~pairDiff[c/2];
    end else begin : g_even
      assign elig[c] = chEn[c];
    end
  end

  always_comb begin
    firstFound = 1'b0; firstCh = '0;
    nextFound  = 1'b0; nextCh  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        firstFound = 1'b1;
        firstCh    = CH_W'(i);
      end
      if (elig[i] && (CH_W'(i) > curCh)) begin
        nextFound = 1'b1;
        nextCh    = CH_W'(i);
      end
    end
  end

  // trigger edge select
  always_comb begin
    unique case (trigMode)
      TRG_RISE: trigEdge = syncQ[1] & ~trigPrev;
      TRG_FALL: trigEdge = ~syncQ[1] & trigPrev;
      TRG_BOTH: trigEdge = syncQ[1] ^ trigPrev;
      default:  trigEdge = 1'b0;
    endcase
  end

  assign swRst    = regWrEn && (regAddr == A_CTRL) && regWrData[0];
  assign swStart  = regWrEn && (regAddr == A_CTRL) && regWrData[1] && !regWrData[0];
  assign startReq = swStart || trigEdge;

  assign dataOff = regAddr - A_DATA;
  assign rdIdx   = dataOff[CH_W+1:2];
  assign isData  = (regAddr >= A_DATA) && (regAddr < (A_DATA + 8'(4*NUM_CH)))
                   && (regAddr[1:0] == 2'b00);

  assign convReq  = busy;
  assign convChan = curCh;
  assign convDiff = busy && !curCh[0] && pairDiff[curCh[CH_W-1:1]];

  always_comb begin
    strb           = '0;
    strb.clrAll    = swRst;
    strb.store     = busy && convAck && !swRst;
    strb.storeCh   = curCh;
    strb.storeDiff = convDiff;
    strb.rdLast    = regRdEn && (regAddr == A_LAST);
    strb.rdCh      = regRdEn && isData;
    strb.rdChIdx   = rdIdx;
    strb.rdOvr     = regRdEn && (regAddr == A_OVR);
  end

  assign irqLine = (|(chRdy & irqEnCh)) | (drdy & irqEnDrdy);

  // read mux
  always_comb begin
    logic [RES_W-1:0] selRes;
    selRes    = chRes[rdIdx];
    regRdData = '0;
    unique case (regAddr)
      A_CHEN:  regRdData[NUM_CH-1:0] = chEn;
      A_IMASK: begin
        regRdData[NUM_CH-1:0] = irqEnCh;
        regRdData[DRDY_BIT]   = irqEnDrdy;
      end
      A_STAT: begin
        regRdData[NUM_CH-1:0] = chRdy;
        regRdData[DRDY_BIT]   = drdy;
      end
      A_OVR:   regRdData[NUM_CH-1:0] = chOvr;
      A_DIFF:  regRdData[DIFF_LSB +: NUM_CH] = diffSel;
      A_TRIG:  regRdData[2:0] = trigMode;
      A_VER:   regRdData = VERSION_ID;
      A_LAST: begin
        regRdData[RES_W-1:0]      = lastRes;
        regRdData[LCH_LSB +: CH_W] = lastCh;
        regRdData[LDIF_BIT]       = lastDiff;
      end
      default: begin
        if (isData) begin
          if (chDiff[rdIdx]) regRdData = {{(32-RES_W){selRes[RES_W-1]}}, selRes};
          else               regRdData = {{(32-RES_W){1'b0}}, selRes};
        end
      end
    endcase
  end

  // synchroniser and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[0], extTrig};
      trigPrev <= syncQ[1];
    end
  end

  // configuration and scan state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chEn <= '0; irqEnCh <= '0; irqEnDrdy <= 1'b0; diffSel <= '0;
      trigMode <= TRG_SOFT; busy <= 1'b0; curCh <= '0;
    end else if (swRst) begin
      chEn <= '0; irqEnCh <= '0; irqEnDrdy <= 1'b0; diffSel <= '0;
      trigMode <= TRG_SOFT; busy <= 1'b0; curCh <= '0;
    end else begin
      if (regWrEn) begin
        unique case (regAddr)
          A_CHSET: chEn <= chEn | regWrData[NUM_CH-1:0];
          A_CHCLR: chEn <= chEn & ~regWrData[NUM_CH-1:0];
          A_IMSET: begin
            irqEnCh   <= irqEnCh | regWrData[NUM_CH-1:0];
            irqEnDrdy <= irqEnDrdy | regWrData[DRDY_BIT];
          end
          A_IMCLR: begin
            irqEnCh   <= irqEnCh & ~regWrData[NUM_CH-1:0];
            irqEnDrdy <= irqEnDrdy & ~regWrData[DRDY_BIT];
          end
          A_DIFF:  diffSel  <= regWrData[DIFF_LSB +: NUM_CH];
          A_TRIG:  trigMode <= trigMode_e'(regWrData[2:0]);
          default: ;
        endcase
      end
      if (!busy) begin
        if (startReq && firstFound) begin
          busy  <= 1'b1;
          curCh <= firstCh;
        end
      end else if (convAck) begin
        if (nextFound) curCh <= nextCh;
        else           busy  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adcRegCore.sv
module adcRegCore
  import adcRegPkg::*;
#(
  parameter logic [31:0] VERSION_ID = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              extTrig,
  output logic              convReq,
  output logic [CH_W-1:0]   convChan,
  output logic              convDiff,
  input  logic              convAck,
  input  logic [RES_W-1:0]  convResult,
  output logic              irq
);
  dpStrobe_t                    strb;
  logic [NUM_CH-1:0][RES_W-1:0] chRes;
  logic [NUM_CH-1:0]            chDiff, chRdy, chOvr;
  logic                         drdy, lastDiff;
  logic [RES_W-1:0]             lastRes;
  logic [CH_W-1:0]              lastCh;

  adcCtrl #(.VERSION_ID(VERSION_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .extTrig(extTrig), .convReq(convReq), .convChan(convChan),
    .convDiff(convDiff), .convAck(convAck), .chRes(chRes), .chDiff(chDiff),
    .chRdy(chRdy), .chOvr(chOvr), .drdy(drdy), .lastRes(lastRes),
    .lastCh(lastCh), .lastDiff(lastDiff), .strb(strb), .irqLine(irq)
  );

  adcData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .convResult(convResult),
    .chRes(chRes), .chDiff(chDiff), .chRdy(chRdy), .chOvr(chOvr),
    .drdy(drdy), .lastRes(lastRes), .lastCh(lastCh), .lastDiff(lastDiff)
  );
endmodule

// File: rtl/adcRegCoreChk.sv
module adcRegCoreChk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [7:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        convReq,
  input logic [3:0]  convChan,
  input logic        convDiff,
  input logic        convAck,
  input logic        irq
);
  logic rstWr;
  assign rstWr = regWrEn && (regAddr == 8'h00) && regWrData[0];

  // R3: pending request stays put until acknowledged
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convAck && !rstWr |=> convReq && $stable(convChan));

  // R3: after an acknowledge the next request is for a higher channel
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rstN)
    convReq && convAck && !rstWr |=> !convReq || (convChan > $past(convChan)));

  // R10: differential requests only name even channels
  a_r10_even_pair: assert property (@(posedge clk) disable iff (!rstN)
    convReq && convDiff |-> !convChan[0]);

  // R1: soft reset leaves no request and no interrupt
  a_r1_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    rstWr |=> !convReq && !irq);

  // R6: interrupt rises only after a stored result or a mask-set write
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(convReq && convAck) || $past(regWrEn && (regAddr == 8'h24)));
endmodule

bind adcRegCore adcRegCoreChk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .convReq(convReq), .convChan(convChan),
  .convDiff(convDiff), .convAck(convAck), .irq(irq)
);

// File: tb/tb_adcRegCore.sv
module tb_adcRegCore;
  localparam logic [31:0] VER = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        extTrig = 1'b0;
  logic        convReq, convDiff;
  logic [3:0]  convChan;
  logic        convAck = 1'b0;
  logic [11:0] convResult = '0;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [11:0] mEn, mDiff, mRdy, mOvr, mMaskCh;
  logic        mMaskD, mDrdy, mLastDiff;
  logic [11:0] mRes [12];
  bit          mResDiff [12];
  logic [11:0] mLastRes;
  logic [3:0]  mLastCh;

  always #2 clk = ~clk;

  adcRegCore #(.VERSION_ID(VER)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .extTrig(extTrig), .convReq(convReq), .convChan(convChan),
    .convDiff(convDiff), .convAck(convAck), .convResult(convResult), .irq(irq)
  );

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  function automatic bit pairD(int k);
    return mDiff[2*k] && mDiff[2*k+1];
  endfunction
  function automatic bit elig(int c);
    return mEn[c] && !((c % 2 == 1) && pairD(c / 2));
  endfunction
  function automatic bit expDiff(int c);
    return (c % 2 == 0) && pairD(c / 2);
  endfunction
  function automatic logic [31:0] expData(int c);
    if (mResDiff[c]) return {{20{mRes[c][11]}}, mRes[c]};
    return {20'b0, mRes[c]};
  endfunction
  function automatic logic [31:0] expStat();
    return {7'b0, mDrdy, 12'b0, mRdy};
  endfunction
  function automatic logic expIrq();
    return (|(mRdy & mMaskCh)) | (mDrdy & mMaskD);
  endfunction

  task automatic clearModel();
    mEn = '0; mDiff = '0; mRdy = '0; mOvr = '0; mMaskCh = '0; mMaskD = 0;
    mDrdy = 0; mLastDiff = 0; mLastRes = '0; mLastCh = '0;
    for (int i = 0; i < 12; i++) begin mRes[i] = '0; mResDiff[i] = 0; end
  endtask

  task automatic idleCheck(input string req, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (convReq) seen = 1;
    end
    chkEq(req, seen, 0);
  endtask

  // serve one full scan; inject disturbs the first request (R8)
  task automatic serviceScan(input int ackDelay, input bit inject);
    bit first = 1;
    for (int c = 0; c < 12; c++) begin
      if (elig(c)) begin
        int w = 0;
        logic [31:0] r;
        while (!convReq && w < 40) begin @(negedge clk); w++; end
        chkEq("R3 request issued", convReq, 1);
        chkEq("R3 ascending channel", convChan, c);
        chkEq("R10 differential flag", convDiff, expDiff(c));
        if (first && inject) begin
          extTrig = 1'b0;
          repeat (4) @(negedge clk);
          extTrig = 1'b1;
          repeat (5) @(negedge clk);
          wr(8'h00, 32'h2);
          chkEq("R8 request unchanged by trigger/start", {convReq, convChan}, {1'b1, 4'(c)});
        end
        repeat (ackDelay) @(negedge clk);
        r = $urandom;
        convResult = r[11:0];
        convAck = 1'b1;
        @(negedge clk);
        convAck = 1'b0;
        if (mRdy[c]) mOvr[c] = 1'b1;
        mRdy[c] = 1'b1; mRes[c] = r[11:0]; mResDiff[c] = expDiff(c);
        mDrdy = 1'b1; mLastRes = r[11:0]; mLastCh = 4'(c); mLastDiff = expDiff(c);
        first = 0;
      end
    end
    idleCheck("R3 scan ends after last channel", 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkEq("R1 no request after reset", convReq, 0);
    chkEq("R1 no irq after reset", irq, 0);
    rd(8'h18, d); chkEq("R1 enable word zero", d, 0);
    rd(8'h2C, d); chkEq("R1 mask zero", d, 0);
    rd(8'h30, d); chkEq("R1 status zero", d, 0);
    rd(8'hC0, d); chkEq("R1 trigger mode zero", d, 0);
    rd(8'h4C, d); chkEq("R1 pair select zero", d, 0);
    rd(8'hFC, d); chkEq("R1 version word", d, VER);

    // R2 set/clear
    wr(8'h10, 32'h0A5); wr(8'h14, 32'h005); wr(8'h10, 0); wr(8'h14, 0);
    rd(8'h18, d); chkEq("R2 enable set/clear", d, 32'h0A0);
    wr(8'h24, 32'h0100_0003); wr(8'h28, 32'h1); wr(8'h24, 0);
    rd(8'h2C, d); chkEq("R2 mask set/clear", d, 32'h0100_0002);
    wr(8'h14, 32'hFFF); wr(8'h28, 32'hFFFF_FFFF);

    // random scans
    for (int it = 0; it < 24; it++) begin
      logic [31:0] r1, r2, r3;
      bit any = 0;
      r1 = $urandom; r2 = $urandom; r3 = $urandom;
      mEn = (it % 6 == 5) ? 12'h0 : r1[11:0];
      mDiff = r2[11:0];
      mMaskCh = r3[11:0]; mMaskD = r3[24];
      wr(8'h14, 32'hFFF); wr(8'h10, {20'b0, mEn});
      wr(8'h28, 32'hFFFF_FFFF); wr(8'h24, {7'b0, mMaskD, 12'b0, mMaskCh});
      wr(8'h4C, {4'b0, mDiff, 16'b0});
      rd(8'h4C, d); chkEq("R10 pair select readback", d, {4'b0, mDiff, 16'b0});
      for (int c = 0; c < 12; c++) if (elig(c)) any = 1;
      wr(8'h00, 32'h2);
      if (!any) idleCheck("R3 no request without eligible channel", 8);
      else serviceScan(int'($urandom % 3), 0);
      chkEq("R6 irq after scan", irq, expIrq());
      rd(8'h30, d); chkEq("R4 status after scan", d, expStat());
      for (int c = 0; c < 12; c++) begin
        if ($urandom % 2 == 1) begin
          rd(8'(8'h50 + 4 * c), d);
          chkEq("R4/R10 data register", d, expData(c));
          mRdy[c] = 1'b0;
        end
      end
      if ($urandom % 2 == 1) begin
        rd(8'h20, d);
        chkEq("R5 last result word", d, {3'b0, mLastDiff, mLastCh, 12'b0, mLastRes});
        mDrdy = 1'b0;
      end
      rd(8'h30, d); chkEq("R4/R5 status after reads", d, expStat());
      chkEq("R6 irq after reads", irq, expIrq());
      rd(8'h3C, d); chkEq("R9 overrun word", d, {20'b0, mOvr});
      mOvr = '0;
      rd(8'h3C, d); chkEq("R9 overrun cleared by read", d, 0);
    end

    // R7 trigger modes on channel 0
    mDiff = '0; wr(8'h4C, 0);
    mEn = 12'h001; wr(8'h14, 32'hFFF); wr(8'h10, 32'h1);
    wr(8'hC0, 32'd1);
    rd(8'hC0, d); chkEq("R7 mode readback", d, 1);
    extTrig = 1'b1; serviceScan(0, 0);
    extTrig = 1'b0; idleCheck("R7 falling ignored in rising mode", 8);
    wr(8'hC0, 32'd2);
    extTrig = 1'b1; idleCheck("R7 rising ignored in falling mode", 8);
    extTrig = 1'b0; serviceScan(1, 0);
    wr(8'hC0, 32'd3);
    extTrig = 1'b1; serviceScan(0, 0);
    extTrig = 1'b0; serviceScan(0, 0);
    wr(8'hC0, 32'd0);
    extTrig = 1'b1; idleCheck("R7 rising ignored in software mode", 8);
    extTrig = 1'b0; idleCheck("R7 falling ignored in software mode", 8);

    // R8 start sources ignored while busy
    mEn = 12'h003; wr(8'h10, 32'h3);
    wr(8'hC0, 32'd1);
    extTrig = 1'b1;
    serviceScan(2, 1);
    idleCheck("R8 no second scan after ignored events", 8);

    // R1 soft reset mid-request
    wr(8'h24, 32'h0100_0FFF);
    wr(8'h00, 32'h2);
    begin
      int w = 0;
      while (!convReq && w < 40) begin @(negedge clk); w++; end
    end
    chkEq("R1 request pending before soft reset", convReq, 1);
    wr(8'h00, 32'h1);
    chkEq("R1 request dropped by soft reset", convReq, 0);
    chkEq("R1 irq low after soft reset", irq, 0);
    rd(8'h18, d); chkEq("R1 enable cleared", d, 0);
    rd(8'h2C, d); chkEq("R1 mask cleared", d, 0);
    rd(8'h30, d); chkEq("R1 status cleared", d, 0);
    rd(8'hC0, d); chkEq("R1 trigger cleared", d, 0);
    rd(8'h20, d); chkEq("R1 last result cleared", d, 0);
    rd(8'h50, d); chkEq("R1 data cleared", d, 0);
    rd(8'hFC, d); chkEq("R1 version after soft reset", d, VER);
    clearModel();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule